// File: doc/BRIEF.md
# Stack Pointer Management Unit

This unit holds the word-aligned stack pointer of a small embedded processor. Each cycle it takes at most one stack operation: push, pop, an adjust by a sign-extended 8-bit immediate, an adjust by a sign-extended 16-bit immediate, or an adjust by a full register value. For a push or a pop it produces a single 32-bit word request toward the data memory. The pointer update is registered at the end of the cycle. The stack grows toward lower addresses, and the pointer always addresses the word pushed most recently.

Every value that reaches the pointer is masked. This applies to computed sums and to values loaded through the direct write port. The two low bits are forced to zero, and so is every bit at or above the data-memory address width `ADDR_W`. Pointer arithmetic therefore wraps modulo the data-memory size. The data memory and the register file are outside this unit. The unit drives a request strobe, a write flag, an address and the write data.

Top module: `stackPtrUnit`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `sp` is zero.
- R2: A push (`opCode` = 1) with `ptrWrEn` low sets `memReq`=1 and `memWrite`=1 in the same cycle. It drives `memAddr` to the masked value of `sp`−4 and `memWData` to `operand`. `sp` takes that address after the clock edge.
- R3: A pop (`opCode` = 2) with `ptrWrEn` low sets `memReq`=1 and `memWrite`=0, with `memAddr` equal to the current `sp`. `sp` becomes the masked value of `sp`+4 after the clock edge.
- R4: `opCode` = 3 adds `operand[7:0]`, sign-extended to 32 bits, to `sp` and issues no memory request.
- R5: `opCode` = 4 adds `operand[15:0]`, sign-extended to 32 bits, to `sp` and issues no memory request.
- R6: `opCode` = 5 adds the full 32-bit `operand` to `sp` and issues no memory request.
- R7: `sp[1:0]` is always zero, whatever value is computed or written.
- R8: Bits `ADDR_W` and above of `sp` are always zero, so pointer arithmetic wraps modulo 2^`ADDR_W`. The default is `ADDR_W` = 16.
- R9: When `ptrWrEn` is high, `sp` is loaded with the masked value of `ptrWrData`. In that cycle the operation on `opCode` is ignored and `memReq` is 0.
- R10: `opCode` values 0, 6 and 7 are no-operations: `memReq` is 0 and `sp` holds its value.
- R11: `spNext` shows, in the same cycle, the value `sp` will take at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opCode | input | 3 | Stack operation: 0 none, 1 push, 2 pop, 3 add imm8, 4 add imm16, 5 add register, 6/7 none |
| operand | input | 32 | Push source value, immediate or register operand |
| ptrWrEn | input | 1 | Direct pointer load strobe |
| ptrWrData | input | 32 | Value for a direct pointer load |
| memReq | output | 1 | Word access request to data memory |
| memWrite | output | 1 | 1 = store, 0 = load, valid with memReq |
| memAddr | output | 32 | Word address of the access |
| memWData | output | 32 | Store data |
| sp | output | 32 | Current stack pointer |
| spNext | output | 32 | Pointer value after this cycle's update |

## Verification
The bench pushes at pointer zero, where a design that failed to mask the decrement would move to 0xFFFFFFFC instead of 0xFFFC. It then pops back through the top of memory, where a missing mask would leave 0x10000 rather than zero. Small positive immediates with low bits set check that alignment is enforced after addition, not only on the operand. Negative 8-bit and 16-bit immediates expose an adjust that zero-extends instead of sign-extending. A direct load that collides with a push checks that the load wins and that no stray store reaches memory. Pop address timing is checked against the pointer value before the increment, which catches a design that increments before it loads.

// File: rtl/stackPtrPkg.sv
package stackPtrPkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_PUSH   = 3'd1,
    OP_POP    = 3'd2,
    OP_ADDI8  = 3'd3,
    OP_ADDI16 = 3'd4,
    OP_ADDREG = 3'd5
  } spOp_e;

  typedef enum logic [1:0] {
    DEL_DEC  = 2'd0,
    DEL_INC  = 2'd1,
    DEL_OPND = 2'd2,
    DEL_LOAD = 2'd3
  } deltaSel_e;

  typedef enum logic [1:0] {
    EXT_B8   = 2'd0,
    EXT_B16  = 2'd1,
    EXT_FULL = 2'd2
  } extSel_e;

  typedef struct packed {
    logic      memReq;
    logic      memWrite;
    logic      update;
    deltaSel_e deltaSel;
    extSel_e   extSel;
  } spCtrl_t;

endpackage

// File: rtl/stackPtrCtrl.sv
module stackPtrCtrl
  import stackPtrPkg::*;
(
  input  logic [2:0] opCode,
  input  logic       ptrWrEn,
  output spCtrl_t    ctrl
);

  always_comb begin
    ctrl          = '0;
    ctrl.deltaSel = DEL_DEC;
    ctrl.extSel   = EXT_FULL;
    if (ptrWrEn) begin
      ctrl.update   = 1'b1;
      ctrl.deltaSel = DEL_LOAD;
    end else begin
      case (opCode)
        OP_PUSH: begin
          ctrl.memReq   = 1'b1;
          ctrl.memWrite = 1'b1;
          ctrl.update   = 1'b1;
          ctrl.deltaSel = DEL_DEC;
        end
        OP_POP: begin
          ctrl.memReq   = 1'b1;
          ctrl.update   = 1'b1;
          ctrl.deltaSel = DEL_INC;
        end
        OP_ADDI8: begin
          ctrl.update   = 1'b1;
          ctrl.deltaSel = DEL_OPND;
          ctrl.extSel   = EXT_B8;
        end
        OP_ADDI16: begin
          ctrl.update   = 1'b1;
          ctrl.deltaSel = DEL_OPND;
          ctrl.extSel   = EXT_B16;
        end
        OP_ADDREG: begin
          ctrl.update   = 1'b1;
          ctrl.deltaSel = DEL_OPND;
          ctrl.extSel   = EXT_FULL;
        end
        default: ctrl.update = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/stackPtrDatapath.sv
module stackPtrDatapath
  import stackPtrPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  spCtrl_t           ctrl,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] ptrWrData,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic [DATA_W-1:0] sp,
  output logic [DATA_W-1:0] spNext
);

  // Legal pointer bits: word aligned, confined to the data-memory span.
  localparam logic [DATA_W-1:0] PTR_MASK =
    {{(DATA_W-ADDR_W){1'b0}}, {(ADDR_W-2){1'b1}}, 2'b00};
  localparam logic [DATA_W-1:0] WORD_BYTES = DATA_W'(4);

  logic [DATA_W-1:0] ptrQ;
  logic [DATA_W-1:0] extOpnd;
  logic [DATA_W-1:0] delta;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] nextRaw;
  logic [DATA_W-1:0] nextMasked;

  always_comb begin
    case (ctrl.extSel)
      EXT_B8:  extOpnd = {{(DATA_W-8){operand[7]}}, operand[7:0]};
      EXT_B16: extOpnd = {{(DATA_W-16){operand[15]}}, operand[15:0]};
      default: extOpnd = operand;
    endcase
  end

  always_comb begin
    case (ctrl.deltaSel)
      DEL_DEC:  delta = ~(WORD_BYTES - DATA_W'(1));
      DEL_INC:  delta = WORD_BYTES;
      DEL_OPND: delta = extOpnd;
      default:  delta = '0;
    endcase
  end

  assign sum        = ptrQ + delta;
  assign nextRaw    = (ctrl.deltaSel == DEL_LOAD) ? ptrWrData : sum;
  assign nextMasked = nextRaw & PTR_MASK;
  assign spNext     = ctrl.update ? nextMasked : ptrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptrQ <= '0;
    else       ptrQ <= spNext;
  end

  // Push stores at the decremented pointer, pop loads at the current one.
  assign memAddr  = ctrl.memWrite ? nextMasked : ptrQ;
  assign memWData = operand;
  assign sp       = ptrQ;

endmodule

// File: rtl/stackPtrUnit.sv
module stackPtrUnit
  import stackPtrPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opCode,
  input  logic [DATA_W-1:0] operand,
  input  logic              ptrWrEn,
  input  logic [DATA_W-1:0] ptrWrData,
  output logic              memReq,
  output logic              memWrite,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic [DATA_W-1:0] sp,
  output logic [DATA_W-1:0] spNext
);

  spCtrl_t ctrl;

  stackPtrCtrl u_ctrl (
    .opCode  (opCode),
    .ptrWrEn (ptrWrEn),
    .ctrl    (ctrl)
  );

  stackPtrDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .operand   (operand),
    .ptrWrData (ptrWrData),
    .memAddr   (memAddr),
    .memWData  (memWData),
    .sp        (sp),
    .spNext    (spNext)
  );

  assign memReq   = ctrl.memReq;
  assign memWrite = ctrl.memWrite;

endmodule

// File: rtl/stackPtrChk.sv
module stackPtrChk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        opCode,
  input logic [DATA_W-1:0] operand,
  input logic              ptrWrEn,
  input logic [DATA_W-1:0] ptrWrData,
  input logic              memReq,
  input logic              memWrite,
  input logic [DATA_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWData,
  input logic [DATA_W-1:0] sp,
  input logic [DATA_W-1:0] spNext
);

  localparam logic [DATA_W-1:0] LEGAL =
    {{(DATA_W-ADDR_W){1'b0}}, {(ADDR_W-2){1'b1}}, 2'b00};

  p_low_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    sp[1:0] == 2'b00);

  p_high_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sp & ~LEGAL) == '0);

  p_push_move_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!ptrWrEn && opCode == 3'd1) |=> sp == (($past(sp) - DATA_W'(4)) & LEGAL));

  p_push_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWrite) |-> (memAddr == ((sp - DATA_W'(4)) & LEGAL) && memWData == operand));

  p_pop_move_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ptrWrEn && opCode == 3'd2) |=> sp == (($past(sp) + DATA_W'(4)) & LEGAL));

  p_pop_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWrite) |-> memAddr == sp);

  p_load_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    ptrWrEn |-> !memReq);

  p_load_value_r9: assert property (@(posedge clk) disable iff (!rstN)
    ptrWrEn |=> sp == ($past(ptrWrData) & LEGAL));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!ptrWrEn && (opCode == 3'd0 || opCode == 3'd6 || opCode == 3'd7)) |=> $stable(sp));

  p_next_match_r11: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> sp == $past(spNext));

endmodule

bind stackPtrUnit stackPtrChk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .opCode(opCode), .operand(operand),
  .ptrWrEn(ptrWrEn), .ptrWrData(ptrWrData), .memReq(memReq),
  .memWrite(memWrite), .memAddr(memAddr), .memWData(memWData),
  .sp(sp), .spNext(spNext)
);

// File: tb/stackPtrUnit_tb.sv
`timescale 1ns/1ps
module stackPtrUnit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic [2:0]  opCode = '0;
  logic [31:0] operand = '0;
  logic        ptrWrEn = 1'b0;
  logic [31:0] ptrWrData = '0;
  logic        memReq, memWrite;
  logic [31:0] memAddr, memWData, sp, spNext;

  int nVec = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  stackPtrUnit u_dut (
    .clk(clk), .rstN(rstN), .opCode(opCode), .operand(operand),
    .ptrWrEn(ptrWrEn), .ptrWrData(ptrWrData), .memReq(memReq),
    .memWrite(memWrite), .memAddr(memAddr), .memWData(memWData),
    .sp(sp), .spNext(spNext)
  );

  // {op[2:0], operand[31:0], req, wr, addr[31:0], spAfter[31:0]}
  localparam int NV = 14;
  localparam logic [100:0] VEC [NV] = '{
    {3'd1, 32'h1111_1111, 1'b1, 1'b1, 32'h0000_FFFC, 32'h0000_FFFC}, // R2 R8 push at 0 wraps
    {3'd1, 32'h2222_2222, 1'b1, 1'b1, 32'h0000_FFF8, 32'h0000_FFF8}, // R2
    {3'd2, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_FFF8, 32'h0000_FFFC}, // R3
    {3'd2, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_FFFC, 32'h0000_0000}, // R3 R8 pop wraps
    {3'd3, 32'h0000_00F0, 1'b0, 1'b0, 32'h0,         32'h0000_FFF0}, // R4 -16
    {3'd3, 32'h0000_007F, 1'b0, 1'b0, 32'h0,         32'h0000_006C}, // R4 R7 +127
    {3'd4, 32'h0000_8000, 1'b0, 1'b0, 32'h0,         32'h0000_806C}, // R5 negative
    {3'd4, 32'hFFFF_0103, 1'b0, 1'b0, 32'h0,         32'h0000_816C}, // R5 R7 upper ignored
    {3'd5, 32'h1234_5673, 1'b0, 1'b0, 32'h0,         32'h0000_D7DC}, // R6 R7 R8
    {3'd0, 32'h0000_FFFF, 1'b0, 1'b0, 32'h0,         32'h0000_D7DC}, // R10
    {3'd7, 32'h0000_FFFF, 1'b0, 1'b0, 32'h0,         32'h0000_D7DC}, // R10
    {3'd1, 32'hCAFE_F00D, 1'b1, 1'b1, 32'h0000_D7D8, 32'h0000_D7D8}, // R2
    {3'd3, 32'h0000_0003, 1'b0, 1'b0, 32'h0,         32'h0000_D7D8}, // R4 R7 +3 truncated
    {3'd5, 32'hFFFF_FFFC, 1'b0, 1'b0, 32'h0,         32'h0000_D7D4}  // R6 -4
  };

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #1 rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check32("R1 sp in reset", sp, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check32("R1 sp after reset", sp, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [100:0] v;
      v = VEC[i];
      @(negedge clk);
      opCode  = v[100:98];
      operand = v[97:66];
      #1;
      check32("R2/R3/R4/R5/R6/R10 memReq", {31'b0, memReq}, {31'b0, v[65]});
      if (v[65]) begin
        check32("R2/R3 memWrite", {31'b0, memWrite}, {31'b0, v[64]});
        check32("R2/R3 memAddr", memAddr, v[63:32]);
        if (v[64]) check32("R2 memWData", memWData, v[97:66]);
      end
      check32("R11 spNext", spNext, v[31:0]);
      @(posedge clk);
      #1;
      check32("R2-R10 sp", sp, v[31:0]);
      check32("R7 R8 legal bits", sp & 32'hFFFF_0003, 32'h0);
    end

    // R9: direct load collides with a push; load wins, no store issued.
    @(negedge clk);
    opCode = 3'd1; operand = 32'h5555_5555;
    ptrWrEn = 1'b1; ptrWrData = 32'hABC1_2347;
    #1;
    check32("R9 no request on load", {31'b0, memReq}, 32'h0);
    @(posedge clk); #1;
    check32("R9 masked load", sp, 32'h0000_2344);
    @(negedge clk);
    ptrWrEn = 1'b0; opCode = 3'd0;
    @(posedge clk); #1;
    check32("R9 held after load", sp, 32'h0000_2344);

    // R2 after load: push from loaded pointer
    @(negedge clk);
    opCode = 3'd1; operand = 32'h0BAD_BEEF;
    #1;
    check32("R2 push addr after load", memAddr, 32'h0000_2340);
    @(negedge clk);
    opCode = 3'd0;

    // R1: reset again mid-run
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check32("R1 async reset", sp, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    check32("R1 after second reset", sp, 32'h0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule